// File: doc/BRIEF.md
# Compressed Byte/Halfword Extension Decoder

This block sits beside the base 16-bit instruction decoder of an RV32 core and recognises the extra code-size instructions that occupy reserved corners of the compressed opcode map. These are byte and halfword loads and stores, a register multiply, four zero/sign-extension forms and a bitwise complement. For each 16-bit word it emits a decoded bundle: an operation code, destination and source register numbers, a zero-extended immediate and an illegal-instruction flag. It is purely combinational. It executes nothing, and it leaves every encoding outside its own slots to the base decoder by reporting "no operation" without flagging it illegal.

The instruction stream passes through with a valid/ready handshake. `in_ready` mirrors `out_ready`, so back-pressure from downstream stalls the producer in the same cycle. A word is consumed on any cycle where `in_valid` and `in_ready` are both high. A word whose two low bits are `11` is a full-width instruction and not a compressed one. Such a word is consumed but produces no output beat. The `ext_en` control pin switches the whole extension on or off. While it is low, every encoding in the extension slots is reported illegal.

Register fields in these encodings are 3-bit compact selectors that address x8 to x15.

Top module: `cmpx_decoder`

## Requirements
- R1: `in_ready` equals `out_ready` at all times. `out_valid` is high exactly when `in_valid` is high and `in_instr[1:0]` is not `11`.
- R2: A word with `in_instr[1:0] = 11` never raises `out_valid`.
- R3: With `in_instr[1:0]=00`, `in_instr[15:13]=100`, bit 12 clear and the extension enabled, bits [11:10] select the operation. The value 0 gives op 1 (unsigned byte load). The value 1 gives a halfword load: op 2 (zero-extending) when bit 6 is 0, and op 3 (sign-extending) when bit 6 is 1. The value 2 gives op 4 (byte store) and the value 3 gives op 5 (halfword store).
- R4: For byte ops (1, 4) the immediate is {bit 5, bit 6}, so bit 5 lands in imm[1] and bit 6 in imm[0]. For halfword ops (2, 3, 5) the immediate is {bit 5, 0}. All higher immediate bits are zero.
- R5: A compact field f maps to register 8+f. Loads take rd from bits [4:2] and rs1 from bits [9:7], with rs2 = 0. Stores take rs1 from bits [9:7] and rs2 from bits [4:2], with rd = 0.
- R6: With `in_instr[1:0]=01`, bits [15:13]=100, [11:10]=11, bit 12=1 and bits [6:5]=2, the result is op 6 (multiply). Here rd = rs1 = 8+bits[9:7], rs2 = 8+bits[4:2] and imm = 0.
- R7: In the same slot with bits [6:5]=3, bits [4:2] select a unary op on rd = rs1 = 8+bits[9:7], with rs2 = 0. The codes are 0 → op 7 (zero-extend byte), 1 → op 8 (sign-extend byte), 2 → op 9 (zero-extend half), 3 → op 10 (sign-extend half) and 5 → op 11 (NOT).
- R8: Unary sub-codes 4, 6 and 7 raise `out_illegal` with op 0.
- R9: Quadrant-1 words with bits [15:13]=100, [11:10]=11 and bit 12=0 give op 0 with `out_illegal` low, for any bits [6:5]. The same holds with bit 12=1 and bits [6:5] of 0 or 1, and for quadrant-2 words.
- R10: With `ext_en` low, every word in the quadrant-0 slot or the multiply/unary slot gives op 0 with `out_illegal` high.
- R11: A quadrant-0 word with bits [15:13]=100 and bit 12 set is illegal (op 0, `out_illegal` high), even when the extension is enabled.
- R12: When op is 0, rd, rs1, rs2 and imm are all 0. `out_illegal` is never high together with a non-zero op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_valid | input | 1 | Incoming instruction word is valid |
| in_ready | output | 1 | Decoder can take the word (mirrors out_ready) |
| in_instr | input | 16 | Compressed instruction word |
| ext_en | input | 1 | Extension enable |
| out_valid | output | 1 | Decoded bundle is valid |
| out_ready | input | 1 | Downstream accepts the bundle |
| out_op | output | 4 | Operation code (0 = none, 1..11 per R3, R6, R7) |
| out_rd | output | 5 | Destination register number |
| out_rs1 | output | 5 | First source register number |
| out_rs2 | output | 5 | Second source register number |
| out_imm | output | 32 | Zero-extended immediate |
| out_illegal | output | 1 | Illegal-instruction flag |

## Verification
Each load and store is tried with several combinations of bits 5 and 6. This shows whether the two immediate bits are swapped or dropped, and whether bit 6 wrongly reaches a halfword offset. Different compact register values in the two fields expose crossed fields or a wrong register base. The unary selector is swept over all eight codes, which separates the five legal operations from the three reserved ones. The base-set encodings next to the slot (bit 12 clear, and funct2 0/1 with bit 12 set) confirm that the extension path does not capture them. Toggling the enable, bit 12 in quadrant 0, and the handshake inputs with full-width words covers the illegal and flow-control paths.

// File: rtl/cmpx_pkg.sv
package cmpx_pkg;

  localparam int REG_W  = 5;
  localparam int CSEL_W = 3;
  localparam int OP_W   = 4;
  localparam logic [REG_W-CSEL_W-1:0] CREG_HI = 2'b01;  // x8..x15

  typedef enum logic [OP_W-1:0] {
    OP_NONE  = 4'd0,
    OP_LBU   = 4'd1,
    OP_LHU   = 4'd2,
    OP_LH    = 4'd3,
    OP_SB    = 4'd4,
    OP_SH    = 4'd5,
    OP_MUL   = 4'd6,
    OP_ZEXTB = 4'd7,
    OP_SEXTB = 4'd8,
    OP_ZEXTH = 4'd9,
    OP_SEXTH = 4'd10,
    OP_NOT   = 4'd11
  } cmpx_op_e;

  function automatic logic [REG_W-1:0] creg(input logic [CSEL_W-1:0] f);
    return {CREG_HI, f};
  endfunction

endpackage

// File: rtl/cmpx_mem_dec.sv
module cmpx_mem_dec
  import cmpx_pkg::*;
#(
  parameter int IMM_W = 32
) (
  input  logic              hit_i,
  input  logic              en_i,
  input  logic              b12_i,
  input  logic [1:0]        sel_i,
  input  logic              b6_i,
  input  logic              b5_i,
  input  logic [CSEL_W-1:0] base_f_i,
  input  logic [CSEL_W-1:0] data_f_i,
  output cmpx_op_e          op_o,
  output logic [REG_W-1:0]  rd_o,
  output logic [REG_W-1:0]  rs1_o,
  output logic [REG_W-1:0]  rs2_o,
  output logic [IMM_W-1:0]  imm_o,
  output logic              illegal_o
);

  logic [1:0] byte_off;
  logic [1:0] half_off;

  assign byte_off = {b5_i, b6_i};
  assign half_off = {b5_i, 1'b0};

  always_comb begin
    op_o      = OP_NONE;
    rd_o      = '0;
    rs1_o     = '0;
    rs2_o     = '0;
    imm_o     = '0;
    illegal_o = 1'b0;
    if (hit_i) begin
      if (!en_i || b12_i) begin
        illegal_o = 1'b1;
      end else begin
        rs1_o = creg(base_f_i);
        unique case (sel_i)
          2'd0: begin
            op_o       = OP_LBU;
            rd_o       = creg(data_f_i);
            imm_o[1:0] = byte_off;
          end
          2'd1: begin
            op_o       = b6_i ? OP_LH : OP_LHU;
            rd_o       = creg(data_f_i);
            imm_o[1:0] = half_off;
          end
          2'd2: begin
            op_o       = OP_SB;
            rs2_o      = creg(data_f_i);
            imm_o[1:0] = byte_off;
          end
          default: begin
            op_o       = OP_SH;
            rs2_o      = creg(data_f_i);
            imm_o[1:0] = half_off;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/cmpx_alu_dec.sv
module cmpx_alu_dec
  import cmpx_pkg::*;
(
  input  logic              hit_i,
  input  logic              en_i,
  input  logic              unary_i,
  input  logic [2:0]        sub_i,
  input  logic [CSEL_W-1:0] dst_f_i,
  input  logic [CSEL_W-1:0] src_f_i,
  output cmpx_op_e          op_o,
  output logic [REG_W-1:0]  rd_o,
  output logic [REG_W-1:0]  rs1_o,
  output logic [REG_W-1:0]  rs2_o,
  output logic              illegal_o
);

  cmpx_op_e un_op;
  logic     un_bad;

  always_comb begin
    un_bad = 1'b0;
    unique case (sub_i)
      3'd0:    un_op = OP_ZEXTB;
      3'd1:    un_op = OP_SEXTB;
      3'd2:    un_op = OP_ZEXTH;
      3'd3:    un_op = OP_SEXTH;
      3'd5:    un_op = OP_NOT;
      default: begin
        un_op  = OP_NONE;
        un_bad = 1'b1;  // word-extend and reserved codes on RV32
      end
    endcase
  end

  always_comb begin
    op_o      = OP_NONE;
    rd_o      = '0;
    rs1_o     = '0;
    rs2_o     = '0;
    illegal_o = 1'b0;
    if (hit_i) begin
      if (!en_i) begin
        illegal_o = 1'b1;
      end else if (!unary_i) begin
        op_o  = OP_MUL;
        rd_o  = creg(dst_f_i);
        rs1_o = creg(dst_f_i);
        rs2_o = creg(src_f_i);
      end else if (un_bad) begin
        illegal_o = 1'b1;
      end else begin
        op_o  = un_op;
        rd_o  = creg(dst_f_i);
        rs1_o = creg(dst_f_i);
      end
    end
  end

endmodule

// File: rtl/cmpx_decoder.sv
module cmpx_decoder
  import cmpx_pkg::*;
#(
  parameter int IMM_W = 32
) (
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [15:0]      in_instr,
  input  logic             ext_en,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OP_W-1:0]  out_op,
  output logic [REG_W-1:0] out_rd,
  output logic [REG_W-1:0] out_rs1,
  output logic [REG_W-1:0] out_rs2,
  output logic [IMM_W-1:0] out_imm,
  output logic             out_illegal
);

  localparam logic [1:0] QUAD_0    = 2'b00;
  localparam logic [1:0] QUAD_1    = 2'b01;
  localparam logic [1:0] QUAD_FULL = 2'b11;
  localparam logic [2:0] SLOT_F3   = 3'b100;

  logic [1:0] quad;
  logic [2:0] f3;
  logic       mem_slot;
  logic       alu_slot;

  assign quad     = in_instr[1:0];
  assign f3       = in_instr[15:13];
  assign mem_slot = (quad == QUAD_0) && (f3 == SLOT_F3);
  assign alu_slot = (quad == QUAD_1) && (f3 == SLOT_F3) &&
                    (in_instr[11:10] == 2'b11) && in_instr[12] && in_instr[6];

  // Handshake: pure pass-through, back-pressure reaches the producer at once.
  assign in_ready  = out_ready;
  assign out_valid = in_valid && (quad != QUAD_FULL);

  cmpx_op_e           m_op, a_op;
  logic [REG_W-1:0]   m_rd, m_rs1, m_rs2, a_rd, a_rs1, a_rs2;
  logic [IMM_W-1:0]   m_imm;
  logic               m_ill, a_ill;

  cmpx_mem_dec #(.IMM_W(IMM_W)) i_mem (
    .hit_i     (mem_slot),
    .en_i      (ext_en),
    .b12_i     (in_instr[12]),
    .sel_i     (in_instr[11:10]),
    .b6_i      (in_instr[6]),
    .b5_i      (in_instr[5]),
    .base_f_i  (in_instr[9:7]),
    .data_f_i  (in_instr[4:2]),
    .op_o      (m_op),
    .rd_o      (m_rd),
    .rs1_o     (m_rs1),
    .rs2_o     (m_rs2),
    .imm_o     (m_imm),
    .illegal_o (m_ill)
  );

  cmpx_alu_dec i_alu (
    .hit_i     (alu_slot),
    .en_i      (ext_en),
    .unary_i   (in_instr[5]),
    .sub_i     (in_instr[4:2]),
    .dst_f_i   (in_instr[9:7]),
    .src_f_i   (in_instr[4:2]),
    .op_o      (a_op),
    .rd_o      (a_rd),
    .rs1_o     (a_rs1),
    .rs2_o     (a_rs2),
    .illegal_o (a_ill)
  );

  always_comb begin
    if (mem_slot) begin
      out_op  = m_op;
      out_rd  = m_rd;
      out_rs1 = m_rs1;
      out_rs2 = m_rs2;
      out_imm = m_imm;
    end else begin
      out_op  = a_op;
      out_rd  = a_rd;
      out_rs1 = a_rs1;
      out_rs2 = a_rs2;
      out_imm = '0;
    end
    out_illegal = m_ill | a_ill;
  end

endmodule

// File: rtl/cmpx_decoder_chk.sv
module cmpx_decoder_chk
  import cmpx_pkg::*;
#(
  parameter int IMM_W = 32
) (
  input logic             in_valid,
  input logic [15:0]      in_instr,
  input logic             ext_en,
  input logic             out_valid,
  input logic [OP_W-1:0]  out_op,
  input logic [REG_W-1:0] out_rd,
  input logic [REG_W-1:0] out_rs1,
  input logic [REG_W-1:0] out_rs2,
  input logic [IMM_W-1:0] out_imm,
  input logic             out_illegal
);

  logic half_op;
  assign half_op = (out_op == OP_LHU) || (out_op == OP_LH) || (out_op == OP_SH);

  always_comb begin
    // R2
    noncomp_quiet_chk: assert (!(in_instr[1:0] == 2'b11 && out_valid));
    // R1
    valid_source_chk: assert (!out_valid || in_valid);
    // R10
    disabled_noop_chk: assert (ext_en || out_op == OP_NONE);
    // R12
    illegal_excl_chk: assert (!(out_illegal && out_op != OP_NONE));
    // R12
    idle_fields_chk: assert (out_op != OP_NONE ||
                             (out_rd == '0 && out_rs1 == '0 && out_rs2 == '0 && out_imm == '0));
    // R5
    creg_range_chk: assert (out_op == OP_NONE || out_rs1[REG_W-1:CSEL_W] == CREG_HI);
    // R4
    imm_span_chk: assert ((out_imm >> 2) == '0);
    // R4
    half_align_chk: assert (!half_op || out_imm[0] == 1'b0);
  end

endmodule

bind cmpx_decoder cmpx_decoder_chk #(.IMM_W(IMM_W)) i_cmpx_decoder_chk (
  .in_valid    (in_valid),
  .in_instr    (in_instr),
  .ext_en      (ext_en),
  .out_valid   (out_valid),
  .out_op      (out_op),
  .out_rd      (out_rd),
  .out_rs1     (out_rs1),
  .out_rs2     (out_rs2),
  .out_imm     (out_imm),
  .out_illegal (out_illegal)
);

// File: tb/test_cmpx_decoder.sv
module test_cmpx_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_instr = 16'h0000;
  logic        ext_en = 1'b1;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [3:0]  out_op;
  logic [4:0]  out_rd, out_rs1, out_rs2;
  logic [31:0] out_imm;
  logic        out_illegal;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk;  // 50 MHz

  cmpx_decoder i_cmpx_decoder (
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_instr    (in_instr),
    .ext_en      (ext_en),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_op      (out_op),
    .out_rd      (out_rd),
    .out_rs1     (out_rs1),
    .out_rs2     (out_rs2),
    .out_imm     (out_imm),
    .out_illegal (out_illegal)
  );

  function automatic logic [15:0] enc_q0(input logic b12, input logic [1:0] sel,
                                         input logic [2:0] base, input logic b6,
                                         input logic b5, input logic [2:0] data);
    return {3'b100, b12, sel, base, b6, b5, data, 2'b00};
  endfunction

  function automatic logic [15:0] enc_q1(input logic b12, input logic [1:0] f2,
                                         input logic [2:0] dst, input logic [2:0] sub);
    return {3'b100, b12, 2'b11, dst, f2, sub, 2'b01};
  endfunction

  task automatic apply(input logic [15:0] w, input logic en);
    @(negedge clk);
    in_instr  = w;
    ext_en    = en;
    in_valid  = 1'b1;
    out_ready = 1'b1;
    #5;
  endtask

  task automatic expect_b(input string req, input logic ev, input logic [3:0] eop,
                          input logic [4:0] erd, input logic [4:0] ers1,
                          input logic [4:0] ers2, input logic [31:0] eimm,
                          input logic eill);
    n_chk++;
    if ({out_valid, out_op, out_rd, out_rs1, out_rs2, out_imm, out_illegal} !==
        {ev, eop, erd, ers1, ers2, eimm, eill}) begin
      n_fail++;
      $display("FAIL %s instr=%h: got v=%0d op=%0d rd=%0d rs1=%0d rs2=%0d imm=%0d ill=%0d exp v=%0d op=%0d rd=%0d rs1=%0d rs2=%0d imm=%0d ill=%0d",
               req, in_instr, out_valid, out_op, out_rd, out_rs1, out_rs2, out_imm, out_illegal,
               ev, eop, erd, ers1, ers2, eimm, eill);
    end
  endtask

  task automatic expect_bit(input string req, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d exp %0d", req, got, exp);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    in_valid = 1'b0;
    #5;
    expect_bit("R1 idle out_valid", out_valid, 1'b0);
  endtask

  task automatic t_loads;
    apply(enc_q0(0, 2'd0, 3'd3, 0, 1, 3'd5), 1);
    expect_b("R3 R4 R5 lbu", 1, 4'd1, 5'd13, 5'd11, 5'd0, 32'd2, 0);
    apply(enc_q0(0, 2'd0, 3'd0, 1, 0, 3'd7), 1);
    expect_b("R4 lbu imm0 from bit6", 1, 4'd1, 5'd15, 5'd8, 5'd0, 32'd1, 0);
    apply(enc_q0(0, 2'd1, 3'd6, 0, 1, 3'd1), 1);
    expect_b("R3 R4 lhu", 1, 4'd2, 5'd9, 5'd14, 5'd0, 32'd2, 0);
    apply(enc_q0(0, 2'd1, 3'd2, 1, 0, 3'd4), 1);
    expect_b("R3 R4 lh bit6 not offset", 1, 4'd3, 5'd12, 5'd10, 5'd0, 32'd0, 0);
  endtask

  task automatic t_stores;
    apply(enc_q0(0, 2'd2, 3'd7, 1, 0, 3'd0), 1);
    expect_b("R3 R5 sb", 1, 4'd4, 5'd0, 5'd15, 5'd8, 32'd1, 0);
    apply(enc_q0(0, 2'd2, 3'd1, 1, 1, 3'd2), 1);
    expect_b("R4 sb imm3", 1, 4'd4, 5'd0, 5'd9, 5'd10, 32'd3, 0);
    apply(enc_q0(0, 2'd3, 3'd4, 0, 1, 3'd6), 1);
    expect_b("R3 R4 sh", 1, 4'd5, 5'd0, 5'd12, 5'd14, 32'd2, 0);
  endtask

  task automatic t_mul;
    apply(enc_q1(1, 2'd2, 3'd2, 3'd6), 1);
    expect_b("R6 mul", 1, 4'd6, 5'd10, 5'd10, 5'd14, 32'd0, 0);
    apply(enc_q1(1, 2'd2, 3'd7, 3'd0), 1);
    expect_b("R6 mul x15 x8", 1, 4'd6, 5'd15, 5'd15, 5'd8, 32'd0, 0);
  endtask

  task automatic t_unary;
    logic [3:0] exp_op [8] = '{4'd7, 4'd8, 4'd9, 4'd10, 4'd0, 4'd11, 4'd0, 4'd0};
    for (int s = 0; s < 8; s++) begin
      apply(enc_q1(1, 2'd3, 3'd5, 3'(s)), 1);
      if (exp_op[s] == 4'd0)
        expect_b("R8 reserved unary", 1, 4'd0, 5'd0, 5'd0, 5'd0, 32'd0, 1);
      else
        expect_b("R7 unary", 1, exp_op[s], 5'd13, 5'd13, 5'd0, 32'd0, 0);
    end
  endtask

  task automatic t_base_passthru;
    for (int f = 0; f < 4; f++) begin
      apply(enc_q1(0, 2'(f), 3'd3, 3'd2), 1);
      expect_b("R9 base op bit12 clear", 1, 4'd0, 5'd0, 5'd0, 5'd0, 32'd0, 0);
    end
    apply(enc_q1(1, 2'd0, 3'd3, 3'd2), 1);
    expect_b("R9 bit12 funct2=0", 1, 4'd0, 5'd0, 5'd0, 5'd0, 32'd0, 0);
    apply(enc_q1(1, 2'd1, 3'd3, 3'd2), 1);
    expect_b("R9 bit12 funct2=1", 1, 4'd0, 5'd0, 5'd0, 5'd0, 32'd0, 0);
    apply(16'h8002, 1);
    expect_b("R9 quadrant 2", 1, 4'd0, 5'd0, 5'd0, 5'd0, 32'd0, 0);
  endtask

  task automatic t_disabled;
    apply(enc_q0(0, 2'd0, 3'd3, 0, 1, 3'd5), 0);
    expect_b("R10 disabled load", 1, 4'd0, 5'd0, 5'd0, 5'd0, 32'd0, 1);
    apply(enc_q1(1, 2'd2, 3'd2, 3'd6), 0);
    expect_b("R10 disabled mul", 1, 4'd0, 5'd0, 5'd0, 5'd0, 32'd0, 1);
    apply(enc_q1(1, 2'd3, 3'd2, 3'd5), 0);
    expect_b("R10 disabled not", 1, 4'd0, 5'd0, 5'd0, 5'd0, 32'd0, 1);
  endtask

  task automatic t_q0_bit12;
    apply(enc_q0(1, 2'd0, 3'd3, 0, 1, 3'd5), 1);
    expect_b("R11 q0 bit12 set", 1, 4'd0, 5'd0, 5'd0, 5'd0, 32'd0, 1);
    apply(enc_q0(1, 2'd3, 3'd3, 0, 1, 3'd5), 1);
    expect_b("R11 q0 bit12 sh slot", 1, 4'd0, 5'd0, 5'd0, 5'd0, 32'd0, 1);
  endtask

  task automatic t_handshake;
    @(negedge clk);
    in_instr = enc_q1(1, 2'd2, 3'd1, 3'd1); in_valid = 1'b1; out_ready = 1'b0;
    #5;
    expect_bit("R1 in_ready low under back-pressure", in_ready, 1'b0);
    expect_bit("R1 out_valid held", out_valid, 1'b1);
    @(negedge clk);
    out_ready = 1'b1;
    #5;
    expect_bit("R1 in_ready follows out_ready", in_ready, 1'b1);
    @(negedge clk);
    in_instr = 16'h0013;
    #5;
    expect_bit("R2 full-width word no beat", out_valid, 1'b0);
    expect_bit("R1 full-width word consumed", in_ready, 1'b1);
    @(negedge clk);
    in_instr = enc_q0(0, 2'd0, 3'd0, 0, 0, 3'd0) | 16'h0003;
    #5;
    expect_bit("R2 slot bits with low 11", out_valid, 1'b0);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: got timeout exp completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset();
    t_loads();
    t_stores();
    t_mul();
    t_unary();
    t_base_passthru();
    t_disabled();
    t_q0_bit12();
    t_handshake();
    done = 1;
    finish_run();
  end

endmodule